// File: doc/BRIEF.md
# Byte-Masked Synchronous RAM with Selectable Collision Read

This block is a single-port synchronous memory built for use inside a larger datapath. Every access happens on the rising clock edge. A write enable, together with one enable per 8-bit lane, decides which bytes of the addressed word get the write data. A read enable loads the addressed word into a registered output. While the read enable is low, that output holds its value.

When one cycle both reads and writes the port's single address, the result depends on a parameter fixed at elaboration:
- **Stored-first (MODE = 0):** the output register takes the word as it stood before the write.
- **Pass-through (MODE = 1):** the output register takes the word as it stands after the write. Each enabled byte shows the incoming data. Each masked byte shows the byte that was already stored, so one output word can mix new and old bytes.

The array itself is never reset. Only the output register clears.

There is no sequencing control, so the block holds no state machine. It has four parts:
- per-lane storage,
- a collision selector, chosen by a generate branch,
- the output register,
- the top module that wires them together.

Top module: `bram_be_rdw`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it goes high, `rdata` is all zeros.
- R2: With `rd_en` high and `wr_en` low, `rdata` after the rising edge equals the word stored at `addr`.
- R3: With `rd_en` low, `rdata` keeps its previous value at the edge, including edges where a write takes place.
- R4: `byte_en[i]` controls bits `[8*i+7:8*i]`. A byte whose enable is low keeps its stored value through a write.
- R5: With MODE = 0, a cycle with `rd_en` and `wr_en` both high loads `rdata` with the word held at `addr` before that write.
- R6: With MODE = 1, a cycle with `rd_en` and `wr_en` both high loads each lane of `rdata` with `wdata` where `byte_en` is high and with the prior stored byte where it is low.
- R7: A write with `rd_en` low updates the array, and a later read returns the written bytes.
- R8: With MODE = 1, a collision with `byte_en` all zeros outputs the unchanged stored word and leaves the array unchanged.
- R9: With `wr_en` low, `byte_en` and `wdata` have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the output register |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request; loads `rdata` |
| addr | input | ADDR_W | Word address shared by read and write |
| wdata | input | DATA_W | Write data |
| byte_en | input | DATA_W/8 | Per-lane write enables |
| rdata | output | DATA_W | Registered read data |

## Verification
The assertions take for granted that every address is written before it is read. They also assume that `addr`, `wdata` and the enables are stable and defined at each rising edge. The bench meets both assumptions:
- It fills every word with `rd_en` low before issuing any read.
- It changes inputs only on the falling edge.
- Its pseudo-random phase draws addresses only from the small, fully initialised depth.

// File: rtl/bram_be_pkg.sv
package bram_be_pkg;

    typedef enum logic {
        RDW_STORED_FIRST = 1'b0,
        RDW_PASS_THROUGH = 1'b1
    } rdw_mode_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/bram_lane_array.sv
module bram_lane_array
    import bram_be_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/LANE_W-1:0]   byte_en,
    output logic [DATA_W-1:0]          stored_word
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && byte_en[ln]) begin
                cells[addr] <= wdata[ln*LANE_W +: LANE_W];
            end
        end

        assign stored_word[ln*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/bram_rdw_select.sv
module bram_rdw_select
    import bram_be_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MODE   = 1
) (
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/LANE_W-1:0]   byte_en,
    input  logic [DATA_W-1:0]          stored_word,
    output logic [DATA_W-1:0]          next_word
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam rdw_mode_e   SEL   = (MODE == 1) ? RDW_PASS_THROUGH : RDW_STORED_FIRST;

    if (SEL == RDW_PASS_THROUGH) begin : g_pass
        for (genvar ln = 0; ln < LANES; ln++) begin : g_mix
            always_comb begin
                if (wr_en && byte_en[ln]) begin
                    next_word[ln*LANE_W +: LANE_W] = wdata[ln*LANE_W +: LANE_W];
                end else begin
                    next_word[ln*LANE_W +: LANE_W] = stored_word[ln*LANE_W +: LANE_W];
                end
            end
        end
    end else begin : g_stored
        always_comb begin
            next_word = stored_word;
        end
    end
endmodule

// File: rtl/bram_out_reg.sv
module bram_out_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/bram_be_rdw.sv
module bram_be_rdw
    import bram_be_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned MODE   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/8-1:0]      byte_en,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] next_word;

    bram_lane_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk         (clk),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .byte_en     (byte_en),
        .stored_word (stored_word)
    );

    bram_rdw_select #(.DATA_W(DATA_W), .MODE(MODE)) u_sel (
        .wr_en       (wr_en),
        .wdata       (wdata),
        .byte_en     (byte_en),
        .stored_word (stored_word),
        .next_word   (next_word)
    );

    bram_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_en),
        .din   (next_word),
        .dout  (rdata)
    );
endmodule

// File: rtl/bram_be_rdw_chk.sv
module bram_be_rdw_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned MODE   = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W/8-1:0] byte_en,
    input logic [DATA_W-1:0]   rdata
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rdata == '0);

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == $past(rdata));

    p_full_write_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && (&byte_en)) ##1 (rd_en && !wr_en && addr == $past(addr))
        |=> rdata == $past(wdata, 2));

    if (MODE == 1) begin : g_pass_chk
        p_flow_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en && (&byte_en)) |=> rdata == $past(wdata));

        p_merge_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && wr_en) ##1 (rd_en && !wr_en && addr == $past(addr))
            |=> $stable(rdata));
    end
endmodule

bind bram_be_rdw bram_be_rdw_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE(MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .byte_en(byte_en), .rdata(rdata)
);

// File: tb/sim_bram_be_rdw.sv
module sim_bram_be_rdw;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int NB = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] byte_en = '0;
    logic [DW-1:0] rdata_new;
    logic [DW-1:0] rdata_old;

    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] exp_new = '0;
    logic [DW-1:0] exp_old = '0;
    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    bram_be_rdw #(.DATA_W(DW), .ADDR_W(AW), .MODE(1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .byte_en(byte_en), .rdata(rdata_new));

    bram_be_rdw #(.DATA_W(DW), .ADDR_W(AW), .MODE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .byte_en(byte_en), .rdata(rdata_old));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic re, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NB-1:0] be, input string req);
        logic [DW-1:0] prior;
        logic [DW-1:0] after;
        @(negedge clk);
        wr_en = we; rd_en = re; addr = a; wdata = d; byte_en = be;
        prior = shadow[a];
        after = prior;
        for (int ln = 0; ln < NB; ln++) begin
            if (we && be[ln]) after[ln*8 +: 8] = d[ln*8 +: 8];
        end
        if (re) begin
            exp_new = after;
            exp_old = prior;
        end
        shadow[a] = after;
        @(posedge clk);
        #1;
        check({req, " pass-through"}, rdata_new, exp_new);
        check({req, " stored-first"}, rdata_old, exp_old);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", rdata_new, '0);
        check("R1 in reset", rdata_old, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", rdata_new, '0);
        check("R1 after release", rdata_old, '0);

        // R7 fill with rd_en low, output must hold (R3)
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b1, 1'b0, AW'(a), DW'(a * 16'h1111 ^ 16'h5AA5), 2'b11, "R7/R3 fill");
        end
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, 1'b1, AW'(a), '0, '0, "R2 read back");
        end

        // R4 masked plain writes, read after
        for (int a = 0; a < DEPTH; a++) begin
            for (int m = 0; m < 4; m++) begin
                step(1'b1, 1'b0, AW'(a), DW'(16'hC300 + a * 16 + m), NB'(m), "R4 masked write");
                step(1'b0, 1'b1, AW'(a), '0, '0, "R4 read after mask");
            end
        end

        // R5/R6/R8 exhaustive collisions
        for (int a = 0; a < DEPTH; a++) begin
            for (int m = 0; m < 4; m++) begin
                step(1'b1, 1'b1, AW'(a), DW'(16'h9E00 ^ (a << 4) ^ m), NB'(m),
                     (m == 0) ? "R8 empty-mask collision" : "R5/R6 collision");
                step(1'b0, 1'b1, AW'(a), '0, '0, "R6 stored after collision");
            end
        end

        // R9 enables with wr_en low
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, 1'b0, AW'(a), 16'hFFFF, 2'b11, "R9 no write hold");
            step(1'b0, 1'b1, AW'(a), 16'h0F0F, 2'b11, "R9 unchanged");
        end

        // R3 idle and writes without read hold output
        step(1'b0, 1'b1, 3'd2, '0, '0, "R2 read");
        step(1'b1, 1'b0, 3'd2, 16'h1234, 2'b11, "R3 hold during write");
        step(1'b0, 1'b0, 3'd5, '0, '0, "R3 hold idle");
        step(1'b0, 1'b1, 3'd2, '0, '0, "R7 read after write");

        // mixed pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] | lfsr[2], AW'(lfsr[5:3]), {lfsr[7:0], lfsr[15:8]} ^ DW'(i),
                 NB'(lfsr[9:8]), "R2/R5/R6 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule